// File: doc/BRIEF.md
# Difference-Ladder FIR Filter

This block is a streaming finite-impulse-response filter with fixed integer coefficients. It computes the direct-form convolution y(j) = sum of C(k)·x(j-k) for k = 0..TAPS-1. Only tap 0 multiplies by a whole coefficient. Every later tap takes the product term of its neighbour, stored one sample earlier, and adds the first-order difference D(k) = C(k) - C(k-1) times the delayed input that belongs to it. The results match a plain direct-form filter exactly. The structure saves hardware only when neighbouring coefficients lie close together, because each multiplier is only as wide as its own difference.

Samples arrive with a valid flag. The delay line and the product-term registers advance only on valid samples, so gaps in the stream have no effect on the result sequence. The full-precision sum appears one cycle after each accepted sample, together with a valid flag.

Top module: `dcm_fir`

## Requirements
- R1: For any input stream, each valid output equals the exact signed sum of C(k)·x(j-k) over all taps, with samples counted only over accepted inputs.
- R2: Coefficient k is taken from bits [k*COEF_W +: COEF_W] of COEFS as a signed value. A single accepted impulse of amplitude A followed by zeros produces the outputs A·C(0), A·C(1), ..., A·C(TAPS-1) in that order, then zero.
- R3: While reset is high at a clock edge, out_valid and out_sample become 0 and the sample history is cleared. After reset, the first TAPS-1 outputs equal the direct-form result with zero history.
- R4: out_valid is high exactly in the cycle after a cycle in which in_valid was high and reset was low. out_sample takes its new value in that same cycle.
- R5: A cycle with in_valid low changes no state. out_sample holds its last value, and in_sample is ignored in that cycle.
- R6: Inputs at full scale, -2^(IN_W-1) and 2^(IN_W-1)-1, give exact outputs with no wrap in any product term or in the sum.
- R7: A constant input A held for at least TAPS accepted samples gives the output A·(sum of all C(k)), and this value stays until the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | in_sample holds a sample to accept |
| in_sample | input | IN_W | Signed input sample |
| out_valid | output | 1 | out_sample holds a new result |
| out_sample | output | IN_W+COEF_W+clog2(TAPS) | Signed full-precision filter output |

## Verification
An impulse from a cleared state shows each coefficient on its own. It therefore exposes a wrong tap order, a wrong difference or a wrong link between neighbouring product terms. A held constant checks that the whole ladder adds up to the coefficient sum. Full-scale values of both signs, alternating and held, check the product and sum widths. Long pseudo-random runs, with and without idle cycles that carry garbage data, are compared every cycle against a behavioural convolution. They separate correct gating of the delay line from correct arithmetic. A reset in the middle of a run shows that no stale history survives.

// File: rtl/dcm_fir_pkg.sv
package dcm_fir_pkg;

   // Smallest two's-complement width holding v (at least 2 bits).
   function automatic int min_sbits(longint v);
      for (int w = 2; w < 63; w++) begin
         if (v >= -(longint'(1) <<< (w - 1)) && v < (longint'(1) <<< (w - 1)))
            return w;
      end
      return 63;
   endfunction

endpackage

// File: rtl/dcm_fir_delay.sv
module dcm_fir_delay #(
   parameter int W     = 12,
   parameter int DEPTH = 7
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      en,
   input  logic [W-1:0]              din,
   output logic [DEPTH-1:0][W-1:0]   dl_q
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("dcm_fir_delay: DEPTH must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         dl_q <= '0;
      end else if (en) begin
         dl_q[0] <= din;
         for (int i = 1; i < DEPTH; i++) dl_q[i] <= dl_q[i-1];
      end
   end

endmodule

// File: rtl/dcm_fir_mul.sv
module dcm_fir_mul #(
   parameter int     IN_W   = 12,
   parameter int     MUL_W  = 8,
   parameter int     T_W    = 28,
   parameter longint FACTOR = 1
) (
   input  logic [IN_W-1:0] x,
   output logic [T_W-1:0]  term
);

   localparam logic signed [MUL_W-1:0] F_S = MUL_W'(FACTOR);

   if (IN_W + MUL_W > T_W) begin : g_bad_width
      $error("dcm_fir_mul: term width too narrow for product");
   end

   logic signed [IN_W+MUL_W-1:0] full;

   assign full = signed'(x) * F_S;
   assign term = T_W'(full);

endmodule

// File: rtl/dcm_fir_tap.sv
module dcm_fir_tap #(
   parameter int P_W = 26,
   parameter int T_W = 28
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            en,
   input  logic [P_W-1:0]  prev_p,
   input  logic [T_W-1:0]  term,
   output logic [P_W-1:0]  prod_q
);

   if (T_W <= P_W) begin : g_bad_width
      $error("dcm_fir_tap: T_W must exceed P_W");
   end

   logic signed [T_W-1:0] nxt;

   assign nxt = T_W'(signed'(prev_p)) + signed'(term);

   always_ff @(posedge clk) begin
      if (rst)     prod_q <= '0;
      else if (en) prod_q <= nxt[P_W-1:0];
   end

   // The exact product term must fit the register width.
   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
      en |-> (nxt == T_W'(signed'(nxt[P_W-1:0]))));

   assert_term_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(prod_q));

   assert_reset_clear_R3: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (prod_q == '0));

endmodule

// File: rtl/dcm_fir_sum.sv
module dcm_fir_sum #(
   parameter int TAPS  = 8,
   parameter int P_W   = 26,
   parameter int OUT_W = 29
) (
   input  logic [TAPS-1:0][P_W-1:0] terms,
   output logic [OUT_W-1:0]         total
);

   if (OUT_W <= P_W) begin : g_bad_width
      $error("dcm_fir_sum: OUT_W must exceed P_W");
   end

   always_comb begin
      total = '0;
      for (int i = 0; i < TAPS; i++)
         total = total + OUT_W'(signed'(terms[i]));
   end

endmodule

// File: rtl/dcm_fir.sv
module dcm_fir #(
   parameter int IN_W   = 12,
   parameter int COEF_W = 14,
   parameter int TAPS   = 8,
   parameter logic [TAPS*COEF_W-1:0] COEFS = {
      14'sd12, 14'sd22, 14'sd30, 14'sd35, 14'sd36, 14'sd33, 14'sd27, 14'sd20}
) (
   input  logic                                  clk,
   input  logic                                  rst,
   input  logic                                  in_valid,
   input  logic [IN_W-1:0]                       in_sample,
   output logic                                  out_valid,
   output logic [IN_W+COEF_W+$clog2(TAPS)-1:0]   out_sample
);
   import dcm_fir_pkg::*;

   localparam int P_W   = IN_W + COEF_W;
   localparam int T_W   = P_W + 2;
   localparam int OUT_W = P_W + $clog2(TAPS);

   if (TAPS < 2) begin : g_bad_taps
      $error("dcm_fir: TAPS must be at least 2");
   end
   if (IN_W < 2 || COEF_W < 2) begin : g_bad_widths
      $error("dcm_fir: IN_W and COEF_W must be at least 2");
   end

   logic [TAPS-2:0][IN_W-1:0] dl_q;
   logic [TAPS-1:0][P_W-1:0]  prod;
   logic [TAPS-1:0][P_W-1:0]  prev;
   logic [TAPS-1:0][T_W-1:0]  term;

   dcm_fir_delay #(.W(IN_W), .DEPTH(TAPS-1)) i_delay (
      .clk  (clk),
      .rst  (rst),
      .en   (in_valid),
      .din  (in_sample),
      .dl_q (dl_q)
   );

   for (genvar k = 0; k < TAPS; k++) begin : g_tap
      localparam logic signed [COEF_W-1:0] CK = COEFS[k*COEF_W +: COEF_W];

      if (k == 0) begin : g_head
         // Leading tap: full coefficient against the live sample.
         dcm_fir_mul #(
            .IN_W(IN_W), .MUL_W(min_sbits(longint'(CK))), .T_W(T_W),
            .FACTOR(longint'(CK))
         ) i_mul (
            .x    (in_sample),
            .term (term[k])
         );
         assign prev[k] = '0;
      end else begin : g_step
         localparam logic signed [COEF_W-1:0] CP = COEFS[(k-1)*COEF_W +: COEF_W];
         localparam longint DK = longint'(CK) - longint'(CP);

         if (DK == 0) begin : g_flat
            assign term[k] = '0;
         end else begin : g_diff
            dcm_fir_mul #(
               .IN_W(IN_W), .MUL_W(min_sbits(DK)), .T_W(T_W), .FACTOR(DK)
            ) i_mul (
               .x    (dl_q[k-1]),
               .term (term[k])
            );
         end
         assign prev[k] = prod[k-1];
      end

      dcm_fir_tap #(.P_W(P_W), .T_W(T_W)) i_tap (
         .clk    (clk),
         .rst    (rst),
         .en     (in_valid),
         .prev_p (prev[k]),
         .term   (term[k]),
         .prod_q (prod[k])
      );
   end

   dcm_fir_sum #(.TAPS(TAPS), .P_W(P_W), .OUT_W(OUT_W)) i_sum (
      .terms (prod),
      .total (out_sample)
   );

   always_ff @(posedge clk) begin
      if (rst) out_valid <= 1'b0;
      else     out_valid <= in_valid;
   end

   assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (out_valid == $past(in_valid)));

   assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_sample));

endmodule

// File: tb/test_dcm_fir.sv
`timescale 1ns/1ps
module test_dcm_fir;

   localparam int IN_W   = 12;
   localparam int COEF_W = 14;
   localparam int TAPS   = 8;
   localparam int OUT_W  = IN_W + COEF_W + 3;
   localparam int C [TAPS] = '{20, 27, 33, 36, 35, 30, 22, 12};

   function automatic logic [TAPS*COEF_W-1:0] pack_coefs();
      logic [TAPS*COEF_W-1:0] r;
      for (int k = 0; k < TAPS; k++) r[k*COEF_W +: COEF_W] = COEF_W'(C[k]);
      return r;
   endfunction

   logic                    clk = 1'b0;
   logic                    rst = 1'b1;
   logic                    in_valid = 1'b0;
   logic [IN_W-1:0]         in_sample = '0;
   logic                    out_valid;
   logic signed [OUT_W-1:0] out_sample;

   dcm_fir #(.IN_W(IN_W), .COEF_W(COEF_W), .TAPS(TAPS), .COEFS(pack_coefs())) i_dcm_fir (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (in_valid),
      .in_sample  (in_sample),
      .out_valid  (out_valid),
      .out_sample (out_sample)
   );

   always #2 clk = ~clk;

   int     n_checks = 0;
   int     n_fails  = 0;
   bit     done     = 1'b0;
   int     hist [TAPS];
   longint exp_y    = 0;
   bit     exp_v    = 1'b0;
   string  tag      = "R3";
   int     seed     = 32'h1357;

   function automatic int rnd();
      seed = seed * 1103515245 + 12345;
      return ((seed >>> 16) & 12'hFFF) - 2048;
   endfunction

   task automatic clear_model();
      for (int k = 0; k < TAPS; k++) hist[k] = 0;
      exp_y = 0;
      exp_v = 1'b0;
   endtask

   task automatic push(int x);
      for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      exp_y = 0;
      for (int k = 0; k < TAPS; k++) exp_y += longint'(C[k]) * longint'(hist[k]);
   endtask

   task automatic compare();
      n_checks++;
      if (out_valid !== exp_v) begin
         n_fails++;
         $display("FAIL R4 out_valid actual=%0b expected=%0b", out_valid, exp_v);
      end
      n_checks++;
      if (longint'(out_sample) !== exp_y) begin
         n_fails++;
         $display("FAIL %s out_sample actual=%0d expected=%0d", tag, out_sample, exp_y);
      end
   endtask

   task automatic step(bit v, int x);
      @(negedge clk);
      compare();
      in_valid  = v;
      in_sample = IN_W'(x);
      if (v) push(x);
      exp_v = v;
   endtask

   // R3: reset clears outputs and history.
   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      clear_model();
      tag = "R3";
      repeat (2) begin
         @(negedge clk);
         compare();
      end
      rst = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      clear_model();
      do_reset();

      // R2: impulse gives the coefficients in tap order.
      tag = "R2";
      step(1'b1, 100);
      for (int i = 0; i < TAPS + 2; i++) step(1'b1, 0);

      // R3: reset in mid-run with nonzero history, then zero-history start.
      for (int i = 0; i < 5; i++) step(1'b1, rnd());
      do_reset();
      tag = "R3";
      for (int i = 0; i < TAPS; i++) step(1'b1, 37 * (i + 1) - 150);

      // R7: constant input settles to A * sum(C) and holds.
      tag = "R7";
      for (int i = 0; i < TAPS + 6; i++) step(1'b1, 500);
      for (int i = 0; i < 3; i++) step(1'b0, 0);

      // R5: idle cycles with garbage data change nothing.
      tag = "R5";
      for (int i = 0; i < 30; i++) begin
         step(1'b1, rnd());
         if (i % 3 == 0) step(1'b0, rnd());
         if (i % 7 == 0) begin
            step(1'b0, 2047);
            step(1'b0, -2048);
         end
      end

      // R6: full-scale inputs of both signs.
      tag = "R6";
      for (int i = 0; i < 12; i++) step(1'b1, (i % 2 == 0) ? 2047 : -2048);
      for (int i = 0; i < TAPS + 2; i++) step(1'b1, -2048);
      for (int i = 0; i < TAPS + 2; i++) step(1'b1, 2047);

      // R1: long pseudo-random run against direct form.
      tag = "R1";
      for (int i = 0; i < 80; i++) step(1'b1, rnd());

      tag = "R4";
      step(1'b0, 0);
      @(negedge clk);
      compare();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule